// File: doc/BRIEF.md
# Programmable Watchdog Timer with Selectable Response

This block guards against runaway software. Software programs a single control and status word that turns the watchdog on, picks one of eight timeout periods and chooses how an expiry is reported. After that it must service the watchdog regularly. It does so either by pulsing the kick input or by writing the control word again. If software does not, the counter runs out of timebase ticks and the block reacts in one of two ways. It either drives a fixed-width system reset pulse or pulls an active-low bus error line, which stays low until software acknowledges it.

The timebase is a one-clock-wide tick input, so the real-time period is set by whatever drives it. The system reset that the block sends out is expected to come back on its system reset input. That reset clears the enable, the response choice and the period choice, so software has to turn the watchdog on again afterwards. A sticky expiry flag survives that reset and is cleared only by power-on reset or by an explicit acknowledge.

Top module: `watchdog_guard`

## Requirements
- R1: The control word sits at byte address 0x08 with these fields: enable in bit 0, response choice in bit 1, period code in bits 4:2 and the sticky expiry flag in bit 7. Every other bit reads as zero. A read at any other address returns zero, and a write to any other address changes nothing.
- R2: While power-on reset is low, every field clears, the reset output is 0 and the bus error output is 1.
- R3: Period code k sets a timeout of 2^(10+2k) ticks. With no further servicing, the expiry takes effect at the clock edge that samples the last of those ticks after the load.
- R4: While enable is 0 the counter is held at zero and no expiry ever happens, whatever the tick and kick inputs do.
- R5: A kick while enabled reloads the full selected period. So does any write to the control word that leaves enable at 1, including one that changes the period code; such a write loads the new code's period at its own edge.
- R6: With response choice 0, an expiry drives the reset output high for exactly 16 clock cycles, starting right after the expiry edge, and leaves the bus error output at 1.
- R7: With response choice 1, an expiry drives the bus error output low right after the expiry edge. It stays low until a write to the control word has bit 7 set, whatever else that write does.
- R8: Every expiry sets the sticky flag. Writing 1 to bit 7 clears it and writing 0 there leaves it alone. The system reset input does not clear it; power-on reset does.
- R9: While the system reset input is high, enable, response choice and period code clear and the counter clears. The watchdog then stays off until software writes enable again.
- R10: The counter moves only on clock cycles where the tick input is high; cycles without a tick leave the remaining time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_i | input | 1 | System reset fed back into the block, active high, synchronous |
| bus_addr | input | 4 | Byte address for the register read and write |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick | input | 1 | Timebase tick, one clock wide |
| kick | input | 1 | Service pulse |
| sys_rst_o | output | 1 | System reset pulse, active high |
| bus_err_n | output | 1 | Bus error, active low |

## Verification
The countdown is driven three ways. With a tick on every cycle the expiry latency must equal the programmed power of two exactly. With a tick on every third cycle, a latency still counted in ticks shows that idle cycles do not move the counter. With regular kicks no expiry may occur. Both responses are fired, which tells the 16-cycle reset pulse apart from the bus error level that is held until acknowledged. Looping the reset output back shows that the control fields clear while the sticky flag stays set. Writes to a wrong address, a disable partway through a count and a period change partway through a count each separate a reload from an ignore or a clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Field positions inside the control word
   localparam int EN_BIT   = 0;
   localparam int MODE_BIT = 1;
   localparam int SEL_LSB  = 2;
   localparam int STAT_BIT = 7;

   // Period scaling variants
   localparam int SCALE_GEOMETRIC = 0;
   localparam int SCALE_LINEAR    = 1;

   typedef enum logic {
      RESP_RESET  = 1'b0,
      RESP_BUSERR = 1'b1
   } resp_e;

endpackage

// File: rtl/wdt_csr.sv
module wdt_csr
   import wdt_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 32,
   parameter int SEL_W      = 3,
   parameter int CSR_OFFSET = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              fire_i,
   output logic              en_o,
   output resp_e             mode_o,
   output logic [SEL_W-1:0]  tsel_o,
   output logic              status_o,
   output logic              wr_hit_o,
   output logic              wr_en_o,
   output logic [SEL_W-1:0]  wr_tsel_o,
   output logic              clr_o
);

   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CSR_OFFSET);

   logic             addr_hit;
   logic             en_q;
   resp_e            mode_q;
   logic [SEL_W-1:0] tsel_q;
   logic             status_q;

   assign addr_hit  = (bus_addr == OFS);
   assign wr_hit_o  = bus_wr && addr_hit;
   assign wr_en_o   = bus_wdata[EN_BIT];
   assign wr_tsel_o = bus_wdata[SEL_LSB +: SEL_W];
   assign clr_o     = wr_hit_o && bus_wdata[STAT_BIT];

   // Control fields: cleared by either reset
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         en_q   <= 1'b0;
         mode_q <= RESP_RESET;
         tsel_q <= '0;
      end else if (sys_rst_i) begin
         en_q   <= 1'b0;
         mode_q <= RESP_RESET;
         tsel_q <= '0;
      end else if (wr_hit_o) begin
         en_q   <= bus_wdata[EN_BIT];
         mode_q <= resp_e'(bus_wdata[MODE_BIT]);
         tsel_q <= bus_wdata[SEL_LSB +: SEL_W];
      end
   end

   // Sticky expiry flag: power-on reset only
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         status_q <= 1'b0;
      end else if (fire_i) begin
         status_q <= 1'b1;
      end else if (clr_o) begin
         status_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (addr_hit) begin
         bus_rdata[EN_BIT]               = en_q;
         bus_rdata[MODE_BIT]             = mode_q;
         bus_rdata[SEL_LSB +: SEL_W]     = tsel_q;
         bus_rdata[STAT_BIT]             = status_q;
      end
   end

   assign en_o     = en_q;
   assign mode_o   = mode_q;
   assign tsel_o   = tsel_q;
   assign status_o = status_q;

   // R9
   csr_sysrst_disable_chk: assert property (@(posedge clk) disable iff (!por_n)
      sys_rst_i |=> !en_q);

   // R8
   status_w1c_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(status_q) |-> $past(clr_o));

   // R8
   status_survives_chk: assert property (@(posedge clk) disable iff (!por_n)
      (status_q && !clr_o) |=> status_q);

endmodule

// File: rtl/wdt_period.sv
module wdt_period
   import wdt_pkg::*;
#(
   parameter int SEL_W      = 3,
   parameter int BASE_EXP   = 10,
   parameter int STEP_EXP   = 2,
   parameter int SCALE_MODE = SCALE_GEOMETRIC,
   parameter int CNT_W      = 25
) (
   input  logic [SEL_W-1:0] tsel_i,
   output logic [CNT_W-1:0] period_o
);

   localparam int NSEL = 1 << SEL_W;

   logic [CNT_W-1:0] tbl [NSEL];

   for (genvar k = 0; k < NSEL; k++) begin : g_tbl
      if (SCALE_MODE == SCALE_GEOMETRIC) begin : g_geo
         localparam int SH = BASE_EXP + STEP_EXP * k;
         assign tbl[k] = CNT_W'(1) << SH;
      end else begin : g_lin
         assign tbl[k] = CNT_W'(k + 1) << BASE_EXP;
      end
   end

   assign period_o = tbl[tsel_i];

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W = 25
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             srst_i,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic             kick_i,
   input  logic             wr_hit_i,
   input  logic             wr_en_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             fire_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             last_tick;

   assign last_tick = tick_i && (cnt_q == CNT_W'(1));
   assign fire_o    = !srst_i && !wr_hit_i && en_i && !kick_i && last_tick;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
      end else if (srst_i) begin
         cnt_q <= '0;
      end else if (wr_hit_i) begin
         cnt_q <= wr_en_i ? period_i : '0;
      end else if (!en_i) begin
         cnt_q <= '0;
      end else if (kick_i) begin
         cnt_q <= period_i;
      end else if (tick_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   // R4
   idle_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!en_i && !wr_hit_i) |=> (cnt_q == '0));

   // R4
   fire_needs_en_chk: assert property (@(posedge clk) disable iff (!por_n)
      fire_o |-> en_i);

   // R10
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (en_i && !tick_i && !kick_i && !wr_hit_i && !srst_i) |=> $stable(cnt_q));

   // R5
   reload_nonzero_chk: assert property (@(posedge clk) disable iff (!por_n)
      (en_i && kick_i && !wr_hit_i && !srst_i) |=> (cnt_q != '0));

endmodule

// File: rtl/wdt_response.sv
module wdt_response
   import wdt_pkg::*;
#(
   parameter int RST_PULSE = 16
) (
   input  logic  clk,
   input  logic  por_n,
   input  logic  fire_i,
   input  resp_e mode_i,
   input  logic  clr_i,
   output logic  sys_rst_o,
   output logic  bus_err_n
);

   logic err_q;

   if (RST_PULSE == 1) begin : g_single
      logic pulse_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) pulse_q <= 1'b0;
         else        pulse_q <= fire_i && (mode_i == RESP_RESET);
      end
      assign sys_rst_o = pulse_q;
   end else begin : g_counted
      localparam int PW = $clog2(RST_PULSE + 1);
      logic [PW-1:0] left_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            left_q <= '0;
         end else if (fire_i && (mode_i == RESP_RESET)) begin
            left_q <= PW'(RST_PULSE);
         end else if (left_q != '0) begin
            left_q <= left_q - PW'(1);
         end
      end
      assign sys_rst_o = (left_q != '0);
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         err_q <= 1'b0;
      end else if (fire_i && (mode_i == RESP_BUSERR)) begin
         err_q <= 1'b1;
      end else if (clr_i) begin
         err_q <= 1'b0;
      end
   end

   assign bus_err_n = !err_q;

   // R6
   rst_from_fire_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sys_rst_o) |-> $past(fire_i && (mode_i == RESP_RESET)));

   // R7
   err_from_fire_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(bus_err_n) |-> $past(fire_i && (mode_i == RESP_BUSERR)));

   // R7
   err_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!bus_err_n && !clr_i) |=> !bus_err_n);

endmodule

// File: rtl/watchdog_guard.sv
module watchdog_guard
   import wdt_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 32,
   parameter int SEL_W      = 3,
   parameter int BASE_EXP   = 10,
   parameter int STEP_EXP   = 2,
   parameter int SCALE_MODE = SCALE_GEOMETRIC,
   parameter int RST_PULSE  = 16,
   parameter int CSR_OFFSET = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick,
   input  logic              kick,
   output logic              sys_rst_o,
   output logic              bus_err_n
);

   localparam int NSEL    = 1 << SEL_W;
   localparam int MAX_EXP = BASE_EXP + STEP_EXP * (NSEL - 1);
   localparam int CNT_W   = (SCALE_MODE == SCALE_GEOMETRIC) ? MAX_EXP + 1
                                                            : BASE_EXP + SEL_W + 1;

   // Elaboration-time parameter checks
   if (DATA_W <= STAT_BIT) begin : g_bad_data_w
      $error("DATA_W too narrow for the control word");
   end
   if (SEL_LSB + SEL_W > STAT_BIT) begin : g_bad_sel_w
      $error("SEL_W overlaps the status bit");
   end
   if (CSR_OFFSET >= (1 << ADDR_W) || (CSR_OFFSET % 4) != 0) begin : g_bad_ofs
      $error("CSR_OFFSET must be word aligned and inside the address window");
   end
   if (RST_PULSE < 1) begin : g_bad_pulse
      $error("RST_PULSE must be at least one cycle");
   end
   if (CNT_W > 32) begin : g_bad_cnt
      $error("timeout range exceeds 32 counter bits");
   end
   if (SCALE_MODE != SCALE_GEOMETRIC && SCALE_MODE != SCALE_LINEAR) begin : g_bad_mode
      $error("unknown SCALE_MODE");
   end

   logic             en;
   resp_e            mode;
   logic [SEL_W-1:0] tsel;
   logic             status;
   logic             wr_hit;
   logic             wr_en;
   logic [SEL_W-1:0] wr_tsel;
   logic             clr;
   logic             fire;
   logic [SEL_W-1:0] period_sel;
   logic [CNT_W-1:0] period;

   wdt_csr #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .SEL_W      (SEL_W),
      .CSR_OFFSET (CSR_OFFSET)
   ) u_csr (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_i (sys_rst_i),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .fire_i    (fire),
      .en_o      (en),
      .mode_o    (mode),
      .tsel_o    (tsel),
      .status_o  (status),
      .wr_hit_o  (wr_hit),
      .wr_en_o   (wr_en),
      .wr_tsel_o (wr_tsel),
      .clr_o     (clr)
   );

   // One decoder serves both reload sources
   assign period_sel = wr_hit ? wr_tsel : tsel;

   wdt_period #(
      .SEL_W      (SEL_W),
      .BASE_EXP   (BASE_EXP),
      .STEP_EXP   (STEP_EXP),
      .SCALE_MODE (SCALE_MODE),
      .CNT_W      (CNT_W)
   ) u_period (
      .tsel_i   (period_sel),
      .period_o (period)
   );

   wdt_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk      (clk),
      .por_n    (por_n),
      .srst_i   (sys_rst_i),
      .en_i     (en),
      .tick_i   (tick),
      .kick_i   (kick),
      .wr_hit_i (wr_hit),
      .wr_en_i  (wr_en),
      .period_i (period),
      .fire_o   (fire)
   );

   wdt_response #(
      .RST_PULSE (RST_PULSE)
   ) u_response (
      .clk       (clk),
      .por_n     (por_n),
      .fire_i    (fire),
      .mode_i    (mode),
      .clr_i     (clr),
      .sys_rst_o (sys_rst_o),
      .bus_err_n (bus_err_n)
   );

   // R8
   fire_sets_status_chk: assert property (@(posedge clk) disable iff (!por_n)
      fire |=> status);

   // R6
   reset_mode_keeps_err_chk: assert property (@(posedge clk) disable iff (!por_n)
      (fire && mode == RESP_RESET && bus_err_n) |=> bus_err_n);

endmodule

// File: tb/watchdog_guard_tb.sv
module watchdog_guard_tb;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic [3:0]  bus_addr = 4'h8;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick = 1'b0;
   logic        kick = 1'b0;
   logic        sys_rst_o;
   logic        bus_err_n;
   wire         sys_rst_i = sys_rst_o;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int tick_mode = 0;   // 0: every cycle, 1: every third cycle, 2: never
   int tick_div = 0;
   int rst_high_cycles = 0;

   // reference model state
   int m_en, m_rsel, m_tsel, m_stat, m_err, m_pulse;
   longint m_cnt;

   always #4 clk = ~clk;   // 125 MHz

   watchdog_guard u_dut (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_i (sys_rst_i),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tick      (tick),
      .kick      (kick),
      .sys_rst_o (sys_rst_o),
      .bus_err_n (bus_err_n)
   );

   function automatic longint per(int k);
      return longint'(1) << (10 + 2 * k);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // behavioural reference, stepped on every edge
   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_en = 0; m_rsel = 0; m_tsel = 0; m_stat = 0; m_err = 0; m_pulse = 0; m_cnt = 0;
      end else begin
         bit srst, whit, fire, clr;
         longint ncnt;
         srst = (m_pulse != 0);
         whit = bus_wr && (bus_addr == 4'h8);
         clr  = whit && bus_wdata[7];
         fire = !srst && !whit && (m_en != 0) && !kick && tick && (m_cnt == 1);
         ncnt = m_cnt;
         if (srst) ncnt = 0;
         else if (whit) ncnt = bus_wdata[0] ? per(int'(bus_wdata[4:2])) : 0;
         else if (m_en == 0) ncnt = 0;
         else if (kick) ncnt = per(m_tsel);
         else if (tick && m_cnt != 0) ncnt = m_cnt - 1;
         if (fire) m_stat = 1; else if (clr) m_stat = 0;
         if (fire && m_rsel == 1) m_err = 1; else if (clr) m_err = 0;
         if (fire && m_rsel == 0) m_pulse = 16; else if (m_pulse != 0) m_pulse--;
         if (srst) begin m_en = 0; m_rsel = 0; m_tsel = 0; end
         else if (whit) begin
            m_en = bus_wdata[0]; m_rsel = bus_wdata[1]; m_tsel = int'(bus_wdata[4:2]);
         end
         m_cnt = ncnt;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      longint exp_rd;
      exp_rd = (bus_addr == 4'h8) ? longint'((m_stat << 7) | (m_tsel << 2) | (m_rsel << 1) | m_en) : 0;
      chk(sys_rst_o == (m_pulse != 0), "R6", sys_rst_o, m_pulse != 0);
      chk(bus_err_n == (m_err == 0), "R7", bus_err_n, m_err == 0);
      chk(longint'(bus_rdata) == exp_rd, "R1", bus_rdata, exp_rd);
      if (sys_rst_o) rst_high_cycles++;
   end

   // timebase
   always @(negedge clk) begin
      #1;
      tick_div = (tick_div == 2) ? 0 : tick_div + 1;
      case (tick_mode)
         0: tick = 1'b1;
         1: tick = (tick_div == 0);
         default: tick = 1'b0;
      endcase
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
         summary();
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0; bus_addr = 4'h8; bus_wdata = '0;
   endtask

   task automatic do_kick();
      @(negedge clk); #1; kick = 1'b1;
      @(negedge clk); #1; kick = 1'b0;
   endtask

   // edges from the write edge until sys_rst_o is seen
   task automatic latency_to_rst(output int n);
      n = 0;
      while (!sys_rst_o && n < 6000) begin
         @(negedge clk); #1; n++;
      end
   endtask

   initial begin
      int n, hi, base;
      idle(3);
      // R2: reset state
      chk(bus_rdata == 0, "R2", bus_rdata, 0);
      chk(sys_rst_o == 0, "R2", sys_rst_o, 0);
      chk(bus_err_n == 1, "R2", bus_err_n, 1);
      @(negedge clk); #1; por_n = 1'b1;
      idle(2);

      // R1: write to a wrong address is ignored
      wr(4'h4, 32'h1);
      chk(bus_rdata == 0, "R1", bus_rdata, 0);
      // R4: disabled watchdog never expires
      base = rst_high_cycles;
      idle(1100);
      chk(rst_high_cycles == base, "R4", rst_high_cycles - base, 0);
      chk(bus_rdata[7] == 0, "R4", bus_rdata[7], 0);

      // R3 / R6 / R9: code 0, reset response, tick every cycle
      wr(4'h8, 32'h01);
      latency_to_rst(n);
      chk(n == 1024, "R3", n, 1024);
      hi = 0;
      while (sys_rst_o && hi < 100) begin
         hi++; @(negedge clk); #1;
      end
      chk(hi == 16, "R6", hi, 16);
      chk(bus_err_n == 1, "R6", bus_err_n, 1);
      // R9 and R8: fields cleared by looped-back reset, flag kept
      chk(bus_rdata == 32'h80, "R9", bus_rdata, 32'h80);
      chk(bus_rdata[7] == 1, "R8", bus_rdata[7], 1);
      base = rst_high_cycles;
      idle(1200);
      chk(rst_high_cycles == base, "R9", rst_high_cycles - base, 0);

      // R8: write-one-to-clear
      wr(4'h8, 32'h00);
      chk(bus_rdata[7] == 1, "R8", bus_rdata[7], 1);
      wr(4'h8, 32'h80);
      chk(bus_rdata == 0, "R8", bus_rdata, 0);

      // R10 / R7: bus error response, tick every third cycle
      tick_mode = 1;
      wr(4'h8, 32'h03);
      idle(3000);
      chk(bus_err_n == 1, "R10", bus_err_n, 1);
      n = 0;
      while (bus_err_n && n < 300) begin
         @(negedge clk); #1; n++;
      end
      chk(bus_err_n == 0, "R7", bus_err_n, 0);
      chk(sys_rst_o == 0, "R7", sys_rst_o, 0);
      idle(50);
      chk(bus_err_n == 0, "R7", bus_err_n, 0);
      wr(4'h8, 32'h03);
      chk(bus_err_n == 0, "R7", bus_err_n, 0);
      wr(4'h8, 32'h80);
      chk(bus_err_n == 1, "R7", bus_err_n, 1);
      chk(bus_rdata == 0, "R7", bus_rdata, 0);

      // R5: kicks keep it alive, then a period change reloads
      tick_mode = 0;
      wr(4'h8, 32'h01);
      base = rst_high_cycles;
      for (int k = 0; k < 5; k++) begin
         idle(1000);
         do_kick();
      end
      chk(rst_high_cycles == base, "R5", rst_high_cycles - base, 0);
      idle(900);
      wr(4'h8, 32'h05);
      latency_to_rst(n);
      chk(n == 4096, "R5", n, 4096);
      idle(30);

      // R4: disable part way through a count
      wr(4'h8, 32'h81);
      idle(500);
      wr(4'h8, 32'h00);
      base = rst_high_cycles;
      idle(2000);
      chk(rst_high_cycles == base, "R4", rst_high_cycles - base, 0);

      // R8: power-on reset clears the sticky flag
      wr(4'h8, 32'h03);
      tick_mode = 2;
      idle(100);
      chk(bus_rdata == 32'h03, "R10", bus_rdata, 32'h03);
      tick_mode = 0;
      idle(1100);
      chk(bus_rdata[7] == 1, "R8", bus_rdata[7], 1);
      @(negedge clk); #1; por_n = 1'b0;
      idle(2);
      chk(bus_rdata == 0, "R8", bus_rdata, 0);
      chk(bus_err_n == 1, "R2", bus_err_n, 1);
      @(negedge clk); #1; por_n = 1'b1;
      idle(3);
      summary();
   end

endmodule